// File: doc/BRIEF.md
# Address Translation Buffer with Access Rights Checking

This block turns a 32-bit virtual address into a 29-bit physical address. It holds a fully associative unified table of 64 page entries and a separate 4-entry table that is used only for instruction fetches. Each entry carries its own page size (1 KB, 4 KB, 64 KB or 1 MB), an address-space tag and a shared flag. It also carries a two-bit rights code and a dirty flag. A request gives the access kind, the privilege level, the current address-space tag and a single-address-space control bit. One cycle later the block returns the physical address and a writable flag, or one exception code.

A replacement index advances on every checked access. It wraps at the table size, or earlier at a programmable base value. Software writes entries through a one-cycle write port. A probe request translates without raising exceptions and without moving the replacement index.

The control follows two named states. In ST_IDLE no response is pending. In ST_RESP the registered result is presented with `rsp_valid` high. The transition T_ACCEPT enters ST_RESP from either state when `req_valid` is high. The transition T_DRAIN returns to ST_IDLE when no request arrives.

Top module: `xlate_tlb_unit`

## Requirements
- R1: After reset, `rsp_valid` is 0, `repl_idx` is 0 and every entry is invalid. `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and the result fields belong to that request.
- R2: Only entries whose valid flag is set can match. A miss returns exception code 1 (load miss) for reads and fetches, and code 2 (store miss) for writes. Codes are 0 none, 1 load miss, 2 store miss, 3 load protection, 4 store protection, 5 initial write.
- R3: The size code is 0=1 KB, 1=4 KB, 2=64 KB and 3=1 MB. A match compares only the address bits above the page offset. The physical address is the virtual page offset ORed with the entry frame bits above that offset, and is limited to 29 bits.
- R4: The address-space tag is not compared when the entry's shared flag is set, or when `req_sv` and `req_priv` are both high. Otherwise the tag must equal `req_asid`.
- R5: A fetch (`req_kind`=2) searches the instruction table first and then the unified table. A read (`req_kind`=0) or a write (`req_kind`=1) searches only the unified table. Within a table, the lowest matching index wins.
- R6: A privileged fetch is always allowed. A user fetch needs bit 1 of the rights code, and otherwise returns code 3. A fetch is never reported as writable.
- R7: For privileged data access, rights codes 0 and 2 are read-only, and a write to them returns code 4. With codes 1 and 3, a write to a page whose dirty flag is 0 returns code 5.
- R8: For user data access, rights codes 0 and 1 return code 3 for a read and code 4 for a write. Code 2 is read-only, and a write to it returns code 4. Code 3 follows the same dirty rule as R7.
- R9: `rsp_writable` is 1 only for an allowed data access to a page that is both writable and dirty. Whenever an exception code is returned, the address and `rsp_writable` are 0.
- R10: Every non-probe request advances `repl_idx` by one. The index becomes 0 when the next value would reach 64, or when `cfg_base` is nonzero and the next value equals it. The index does not change without a request.
- R11: A probe request (`req_probe`=1) never returns an exception code and leaves `repl_idx` unchanged. A probe that would fault returns address 0 and `rsp_writable` 0. A probe that hits returns the normal translation.
- R12: An entry write through the write port takes effect at the end of its cycle. A lookup in the same cycle sees the previous contents of that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_priv | input | 1 | Privileged access |
| req_asid | input | 8 | Current address-space tag |
| req_sv | input | 1 | Single-address-space mode |
| req_probe | input | 1 | Probe: no exception, no index update |
| cfg_base | input | 6 | Replacement wrap base (0 = none) |
| wr_en | input | 1 | Entry write strobe |
| wr_itlb | input | 1 | 1 selects the instruction table |
| wr_idx | input | 6 | Entry index |
| wr_vpn | input | 22 | Virtual page bits 31:10 |
| wr_asid | input | 8 | Entry address-space tag |
| wr_frame | input | 19 | Physical frame bits 28:10 |
| wr_size | input | 2 | Page size code |
| wr_valid | input | 1 | Entry valid flag |
| wr_shared | input | 1 | Entry shared flag |
| wr_dirty | input | 1 | Entry dirty flag |
| wr_prot | input | 2 | Entry rights code |
| rsp_valid | output | 1 | Result valid |
| rsp_paddr | output | 29 | Physical address |
| rsp_writable | output | 1 | Page usable for writes |
| rsp_exc | output | 3 | Exception code |
| repl_idx | output | 6 | Replacement index |

## Verification
Two things can happen in the same cycle: an entry write through the write port and a lookup of the address that the entry maps. The bench provokes this by asserting `wr_en` and `req_valid` together for an address that is not yet mapped. It expects a load miss from that lookup and a hit from the next lookup of the same address. The same idea is applied to the replacement index: a probe issued between counted requests must leave the index where the counted requests put it.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    localparam int VA_W   = 32;
    localparam int PA_W   = 29;
    localparam int OFS_W  = 10;
    localparam int PG_W   = VA_W - OFS_W;
    localparam int FR_W   = PA_W - OFS_W;
    localparam int ASID_W = 8;

    typedef enum logic [1:0] {
        PG_1K  = 2'd0,
        PG_4K  = 2'd1,
        PG_64K = 2'd2,
        PG_1M  = 2'd3
    } pg_size_e;

    typedef enum logic [2:0] {
        EXC_NONE    = 3'd0,
        EXC_LD_MISS = 3'd1,
        EXC_ST_MISS = 3'd2,
        EXC_LD_PROT = 3'd3,
        EXC_ST_PROT = 3'd4,
        EXC_INIT_WR = 3'd5
    } exc_e;

    typedef struct packed {
        logic              valid;
        logic              shared;
        logic              dirty;
        logic [1:0]        prot;
        pg_size_e          size;
        logic [ASID_W-1:0] asid;
        logic [PG_W-1:0]   vpn;
        logic [FR_W-1:0]   frame;
    } tlb_ent_t;

    // Mask over address bits 31:10; a set bit is compared / taken from the frame.
    function automatic logic [PG_W-1:0] page_mask(input pg_size_e sz);
        logic [PG_W-1:0] m;
        m = '1;
        unique case (sz)
            PG_1K:  m = '1;
            PG_4K:  m[1:0] = '0;
            PG_64K: m[5:0] = '0;
            PG_1M:  m[9:0] = '0;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/xlt_cam.sv
module xlt_cam
    import xlt_pkg::*;
#(
    parameter int N     = 64,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  tlb_ent_t             wr_ent,
    input  logic [PG_W-1:0]      lk_vpn,
    input  logic [ASID_W-1:0]    lk_asid,
    input  logic                 asid_skip,
    output logic                 hit,
    output tlb_ent_t             hit_ent
);
    tlb_ent_t       ent_q [N];
    logic [N-1:0]   match;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) ent_q[i] <= '0;
        end else if (wr_en) begin
            ent_q[wr_idx] <= wr_ent;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic [PG_W-1:0] m;
        logic            tag_ok;
        assign m      = page_mask(ent_q[g].size);
        assign tag_ok = ent_q[g].shared || asid_skip || (ent_q[g].asid == lk_asid);
        assign match[g] = ent_q[g].valid && (((ent_q[g].vpn ^ lk_vpn) & m) == '0) && tag_ok;
    end

    // Priority pick: lowest index wins.
    always_comb begin
        hit     = 1'b0;
        hit_ent = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_ent = ent_q[i];
            end
        end
    end
endmodule

// File: rtl/xlt_perm.sv
module xlt_perm
    import xlt_pkg::*;
(
    input  logic       hit,
    input  logic       is_fetch,
    input  logic       is_write,
    input  logic       priv,
    input  logic [1:0] prot,
    input  logic       dirty,
    output exc_e       exc,
    output logic       writable
);
    logic user_ok;

    assign user_ok = priv || prot[1];

    always_comb begin
        exc      = EXC_NONE;
        writable = 1'b0;
        if (!hit) begin
            exc = is_write ? EXC_ST_MISS : EXC_LD_MISS;
        end else if (is_fetch) begin
            if (!priv && !prot[1]) exc = EXC_LD_PROT;
        end else if (!user_ok) begin
            exc = is_write ? EXC_ST_PROT : EXC_LD_PROT;
        end else if (!prot[0]) begin
            if (is_write) exc = EXC_ST_PROT;
        end else if (is_write && !dirty) begin
            exc = EXC_INIT_WR;
        end else begin
            writable = dirty;
        end
    end
endmodule

// File: rtl/xlt_repl_ctr.sv
module xlt_repl_ctr #(
    parameter int N     = 64,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [IDX_W-1:0] base,
    output logic [IDX_W-1:0] idx_q
);
    localparam logic [IDX_W:0] LIMIT = IDX_W'(N - 1) + 1'b1;

    logic [IDX_W:0] nxt;
    logic           wrap;

    assign nxt  = {1'b0, idx_q} + 1'b1;
    assign wrap = (nxt >= LIMIT) || ((base != '0) && (nxt == {1'b0, base}));

    always_ff @(posedge clk) begin
        if (!rst_n)    idx_q <= '0;
        else if (step) idx_q <= wrap ? '0 : nxt[IDX_W-1:0];
    end
endmodule

// File: rtl/xlate_tlb_unit.sv
module xlate_tlb_unit
    import xlt_pkg::*;
#(
    parameter int UTLB_N = 64,
    parameter int ITLB_N = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [31:0]                   req_vaddr,
    input  logic [1:0]                    req_kind,
    input  logic                          req_priv,
    input  logic [7:0]                    req_asid,
    input  logic                          req_sv,
    input  logic                          req_probe,
    input  logic [$clog2(UTLB_N)-1:0]     cfg_base,
    input  logic                          wr_en,
    input  logic                          wr_itlb,
    input  logic [$clog2(UTLB_N)-1:0]     wr_idx,
    input  logic [21:0]                   wr_vpn,
    input  logic [7:0]                    wr_asid,
    input  logic [18:0]                   wr_frame,
    input  logic [1:0]                    wr_size,
    input  logic                          wr_valid,
    input  logic                          wr_shared,
    input  logic                          wr_dirty,
    input  logic [1:0]                    wr_prot,
    output logic                          rsp_valid,
    output logic [28:0]                   rsp_paddr,
    output logic                          rsp_writable,
    output logic [2:0]                    rsp_exc,
    output logic [$clog2(UTLB_N)-1:0]     repl_idx
);
    localparam int U_IDX_W = $clog2(UTLB_N);
    localparam int I_IDX_W = (ITLB_N > 1) ? $clog2(ITLB_N) : 1;

    typedef enum logic {ST_IDLE, ST_RESP} st_e;
    st_e state_q, state_d;

    tlb_ent_t        wr_ent, u_ent, i_ent, sel_ent;
    logic            u_hit, i_hit, sel_hit;
    logic            is_fetch, is_write, asid_skip;
    exc_e            exc_c;
    logic            wrbl_c;
    logic [PG_W-1:0] sel_mask;
    logic [FR_W-1:0] pa_page;
    logic [PA_W-1:0] pa_c;

    assign is_fetch  = (req_kind == 2'd2);
    assign is_write  = (req_kind == 2'd1);
    assign asid_skip = req_sv && req_priv;

    assign wr_ent = '{valid: wr_valid, shared: wr_shared, dirty: wr_dirty,
                      prot: wr_prot, size: pg_size_e'(wr_size), asid: wr_asid,
                      vpn: wr_vpn, frame: wr_frame};

    xlt_cam #(.N(UTLB_N), .IDX_W(U_IDX_W)) u_utlb (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en && !wr_itlb), .wr_idx(wr_idx), .wr_ent(wr_ent),
        .lk_vpn(req_vaddr[VA_W-1:OFS_W]), .lk_asid(req_asid), .asid_skip(asid_skip),
        .hit(u_hit), .hit_ent(u_ent)
    );

    xlt_cam #(.N(ITLB_N), .IDX_W(I_IDX_W)) u_itlb (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en && wr_itlb), .wr_idx(wr_idx[I_IDX_W-1:0]), .wr_ent(wr_ent),
        .lk_vpn(req_vaddr[VA_W-1:OFS_W]), .lk_asid(req_asid), .asid_skip(asid_skip),
        .hit(i_hit), .hit_ent(i_ent)
    );

    // Fetches try the instruction table first.
    always_comb begin
        if (is_fetch && i_hit) begin
            sel_hit = 1'b1;
            sel_ent = i_ent;
        end else begin
            sel_hit = u_hit;
            sel_ent = u_ent;
        end
    end

    xlt_perm u_perm (
        .hit(sel_hit), .is_fetch(is_fetch), .is_write(is_write), .priv(req_priv),
        .prot(sel_ent.prot), .dirty(sel_ent.dirty), .exc(exc_c), .writable(wrbl_c)
    );

    assign sel_mask = page_mask(sel_ent.size);
    assign pa_page  = (req_vaddr[PA_W-1:OFS_W] & ~sel_mask[FR_W-1:0])
                    | (sel_ent.frame & sel_mask[FR_W-1:0]);
    assign pa_c     = {pa_page, req_vaddr[OFS_W-1:0]};

    xlt_repl_ctr #(.N(UTLB_N), .IDX_W(U_IDX_W)) u_repl (
        .clk(clk), .rst_n(rst_n), .step(req_valid && !req_probe),
        .base(cfg_base), .idx_q(repl_idx)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: T_ACCEPT on a request, T_DRAIN otherwise.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
        endcase
    end

    assign rsp_valid = (state_q == ST_RESP);

    // Result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_paddr    <= '0;
            rsp_writable <= 1'b0;
            rsp_exc      <= EXC_NONE;
        end else if (req_valid) begin
            if (exc_c != EXC_NONE) begin
                rsp_paddr    <= '0;
                rsp_writable <= 1'b0;
                rsp_exc      <= req_probe ? EXC_NONE : exc_c;
            end else begin
                rsp_paddr    <= pa_c;
                rsp_writable <= wrbl_c;
                rsp_exc      <= EXC_NONE;
            end
        end
    end
endmodule

// File: rtl/xlt_chk.sv
module xlt_chk #(
    parameter int U_IDX_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [1:0]         req_kind,
    input logic               req_probe,
    input logic               rsp_valid,
    input logic [28:0]        rsp_paddr,
    input logic               rsp_writable,
    input logic [2:0]         rsp_exc,
    input logic [U_IDX_W-1:0] repl_idx
);
    // R1
    resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R1
    resp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R2
    exc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_exc <= 3'd5));
    // R9
    exc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc != 3'd0) |-> (rsp_paddr == '0 && !rsp_writable));
    // R11
    probe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_probe) |=> (rsp_exc == 3'd0 && $stable(repl_idx)));
    // R10
    ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(repl_idx));
    // R6
    fetch_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd2) |=> !rsp_writable);
    // R7
    store_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd1 && !req_probe) |=>
        (rsp_exc == 3'd0 || rsp_exc == 3'd2 || rsp_exc == 3'd4 || rsp_exc == 3'd5));
endmodule

bind xlate_tlb_unit xlt_chk #(.U_IDX_W(U_IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_probe(req_probe), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_writable(rsp_writable), .rsp_exc(rsp_exc), .repl_idx(repl_idx)
);

// File: tb/tb_xlate_tlb_unit.sv
`timescale 1ns/1ps
module tb_xlate_tlb_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_priv, req_sv, req_probe;
    logic [31:0] req_vaddr;
    logic [1:0]  req_kind;
    logic [7:0]  req_asid;
    logic [5:0]  cfg_base;
    logic        wr_en, wr_itlb, wr_valid, wr_shared, wr_dirty;
    logic [5:0]  wr_idx;
    logic [21:0] wr_vpn;
    logic [7:0]  wr_asid;
    logic [18:0] wr_frame;
    logic [1:0]  wr_size, wr_prot;
    logic        rsp_valid, rsp_writable;
    logic [28:0] rsp_paddr;
    logic [2:0]  rsp_exc;
    logic [5:0]  repl_idx;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    xlate_tlb_unit dut (.*);

    typedef struct packed {
        logic [15:0] tag;
        logic [1:0]  kind;
        logic        priv;
        logic        sv;
        logic [7:0]  asid;
        logic [31:0] va;
        logic [2:0]  exc;
        logic        wr;
        logic [28:0] pa;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{"R3", 2'd0, 1'b0, 1'b0, 8'h05, 32'h00400ABC, 3'd0, 1'b1, 29'h01234ABC},
        '{"R8", 2'd1, 1'b0, 1'b0, 8'h05, 32'h00400ABC, 3'd0, 1'b1, 29'h01234ABC},
        '{"R4", 2'd0, 1'b0, 1'b0, 8'h06, 32'h00400ABC, 3'd1, 1'b0, 29'h0},
        '{"R4", 2'd0, 1'b1, 1'b1, 8'h06, 32'h00400ABC, 3'd0, 1'b1, 29'h01234ABC},
        '{"R4", 2'd0, 1'b1, 1'b0, 8'h06, 32'h00400ABC, 3'd1, 1'b0, 29'h0},
        '{"R4", 2'd0, 1'b0, 1'b0, 8'h01, 32'h008003FF, 3'd0, 1'b0, 29'h000023FF},
        '{"R8", 2'd1, 1'b0, 1'b0, 8'h01, 32'h008003FF, 3'd4, 1'b0, 29'h0},
        '{"R7", 2'd1, 1'b1, 1'b0, 8'h01, 32'h008003FF, 3'd4, 1'b0, 29'h0},
        '{"R3", 2'd0, 1'b0, 1'b0, 8'h01, 32'h00800400, 3'd1, 1'b0, 29'h0},
        '{"R3", 2'd0, 1'b1, 1'b0, 8'h05, 32'h10001234, 3'd0, 1'b0, 29'h0AB51234},
        '{"R7", 2'd1, 1'b1, 1'b0, 8'h05, 32'h10001234, 3'd5, 1'b0, 29'h0},
        '{"R8", 2'd0, 1'b0, 1'b0, 8'h05, 32'h10001234, 3'd3, 1'b0, 29'h0},
        '{"R8", 2'd1, 1'b0, 1'b0, 8'h05, 32'h1000FFFF, 3'd4, 1'b0, 29'h0},
        '{"R3", 2'd0, 1'b1, 1'b0, 8'h05, 32'h200ABCDE, 3'd0, 1'b0, 29'h1F0ABCDE},
        '{"R7", 2'd1, 1'b1, 1'b0, 8'h05, 32'h200ABCDE, 3'd4, 1'b0, 29'h0},
        '{"R8", 2'd0, 1'b0, 1'b0, 8'h05, 32'h200ABCDE, 3'd3, 1'b0, 29'h0},
        '{"R2", 2'd0, 1'b1, 1'b0, 8'h05, 32'h30000010, 3'd1, 1'b0, 29'h0},
        '{"R2", 2'd1, 1'b1, 1'b0, 8'h05, 32'h30000010, 3'd2, 1'b0, 29'h0},
        '{"R5", 2'd2, 1'b0, 1'b0, 8'h05, 32'h00400010, 3'd0, 1'b0, 29'h07777010},
        '{"R5", 2'd0, 1'b0, 1'b0, 8'h05, 32'h00400010, 3'd0, 1'b1, 29'h01234010},
        '{"R6", 2'd2, 1'b0, 1'b0, 8'h05, 32'h50000020, 3'd3, 1'b0, 29'h0},
        '{"R6", 2'd2, 1'b1, 1'b0, 8'h05, 32'h50000020, 3'd0, 1'b0, 29'h00200020},
        '{"R6", 2'd2, 1'b0, 1'b0, 8'h05, 32'h20000010, 3'd3, 1'b0, 29'h0},
        '{"R6", 2'd2, 1'b1, 1'b0, 8'h05, 32'h20000010, 3'd0, 1'b0, 29'h1F000010},
        '{"R2", 2'd2, 1'b1, 1'b0, 8'h05, 32'h60000000, 3'd1, 1'b0, 29'h0},
        '{"R5", 2'd0, 1'b1, 1'b0, 8'h05, 32'h40000004, 3'd0, 1'b1, 29'h00100004},
        '{"R9", 2'd0, 1'b1, 1'b0, 8'h05, 32'h00400FFF, 3'd0, 1'b1, 29'h01234FFF}
    };

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic put_ent(input bit itlb, input int idx, input logic [21:0] vpn,
                           input logic [7:0] asid, input logic [18:0] frame,
                           input logic [1:0] size, input bit v, input bit sh,
                           input bit d, input logic [1:0] prot);
        @(negedge clk);
        wr_en = 1; wr_itlb = itlb; wr_idx = 6'(idx); wr_vpn = vpn; wr_asid = asid;
        wr_frame = frame; wr_size = size; wr_valid = v; wr_shared = sh;
        wr_dirty = d; wr_prot = prot;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic do_req(input logic [1:0] kind, input bit priv, input bit sv,
                          input bit probe, input logic [7:0] asid, input logic [31:0] va);
        @(negedge clk);
        req_valid = 1; req_kind = kind; req_priv = priv; req_sv = sv;
        req_probe = probe; req_asid = asid; req_vaddr = va;
        @(posedge clk); #1;
        req_valid = 0; req_probe = 0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
        end
    end

    initial begin
        logic [5:0] held;
        rst_n = 0; req_valid = 0; req_vaddr = 0; req_kind = 0; req_priv = 0;
        req_asid = 0; req_sv = 0; req_probe = 0; cfg_base = 0;
        wr_en = 0; wr_itlb = 0; wr_idx = 0; wr_vpn = 0; wr_asid = 0; wr_frame = 0;
        wr_size = 0; wr_valid = 0; wr_shared = 0; wr_dirty = 0; wr_prot = 0;
        repeat (3) @(posedge clk); #1;
        rst_n = 1;
        // R1 reset state
        chk("R1", "rsp_valid after reset", 32'(rsp_valid), 0);
        chk("R1", "repl_idx after reset", 32'(repl_idx), 0);

        // Unified entries
        put_ent(0, 0,  22'h001000, 8'h05, 19'h048D0, 2'd1, 1, 0, 1, 2'd3);
        put_ent(0, 1,  22'h002000, 8'h09, 19'h00008, 2'd0, 1, 1, 0, 2'd2);
        put_ent(0, 2,  22'h04003F, 8'h05, 19'h2AD7F, 2'd2, 1, 0, 0, 2'd1);
        put_ent(0, 3,  22'h080000, 8'h05, 19'h7C000, 2'd3, 1, 0, 1, 2'd0);
        put_ent(0, 4,  22'h001000, 8'h05, 19'h15554, 2'd1, 1, 0, 1, 2'd3);
        put_ent(0, 5,  22'h0C0000, 8'h05, 19'h00100, 2'd1, 0, 0, 1, 2'd3);
        put_ent(0, 63, 22'h100000, 8'h05, 19'h00400, 2'd1, 1, 0, 1, 2'd3);
        // Instruction entries
        put_ent(1, 0,  22'h001000, 8'h05, 19'h1DDDC, 2'd1, 1, 0, 0, 2'd2);
        put_ent(1, 1,  22'h140000, 8'h05, 19'h00800, 2'd1, 1, 0, 0, 2'd1);

        for (int k = 0; k < NV; k++) begin
            do_req(VECS[k].kind, VECS[k].priv, VECS[k].sv, 1'b0, VECS[k].asid, VECS[k].va);
            chk(string'(VECS[k].tag), $sformatf("vec %0d valid", k), 32'(rsp_valid), 1);
            chk(string'(VECS[k].tag), $sformatf("vec %0d exc", k), 32'(rsp_exc), 32'(VECS[k].exc));
            chk(string'(VECS[k].tag), $sformatf("vec %0d writable", k), 32'(rsp_writable), 32'(VECS[k].wr));
            chk(string'(VECS[k].tag), $sformatf("vec %0d paddr", k), 32'(rsp_paddr), 32'(VECS[k].pa));
        end
        @(posedge clk); #1;
        chk("R1", "rsp_valid drops", 32'(rsp_valid), 0);

        // R11 probe: fault hidden, counter held
        held = repl_idx;
        do_req(2'd1, 1, 0, 1, 8'h05, 32'h60000000);
        chk("R11", "probe miss exc", 32'(rsp_exc), 0);
        chk("R11", "probe miss paddr", 32'(rsp_paddr), 0);
        chk("R11", "probe miss writable", 32'(rsp_writable), 0);
        chk("R11", "probe index held", 32'(repl_idx), 32'(held));
        do_req(2'd0, 0, 0, 1, 8'h05, 32'h00400ABC);
        chk("R11", "probe hit paddr", 32'(rsp_paddr), 32'h01234ABC);
        chk("R11", "probe hit index held", 32'(repl_idx), 32'(held));

        // R12 write and lookup in the same cycle
        @(negedge clk);
        wr_en = 1; wr_itlb = 0; wr_idx = 6'd6; wr_vpn = 22'h1C0000; wr_asid = 8'h05;
        wr_frame = 19'h01000; wr_size = 2'd1; wr_valid = 1; wr_shared = 0;
        wr_dirty = 1; wr_prot = 2'd3;
        req_valid = 1; req_kind = 2'd0; req_priv = 1; req_sv = 0; req_asid = 8'h05;
        req_vaddr = 32'h70000123;
        @(posedge clk); #1;
        wr_en = 0; req_valid = 0;
        chk("R12", "same-cycle lookup sees old entry", 32'(rsp_exc), 1);
        do_req(2'd0, 1, 0, 0, 8'h05, 32'h70000123);
        chk("R12", "next lookup exc", 32'(rsp_exc), 0);
        chk("R12", "next lookup paddr", 32'(rsp_paddr), 32'h00400123);

        // R10 counter wrap, R1 reset clears entries
        @(negedge clk); rst_n = 0;
        @(posedge clk); #1; rst_n = 1;
        chk("R1", "rsp_valid after second reset", 32'(rsp_valid), 0);
        chk("R1", "repl_idx after second reset", 32'(repl_idx), 0);
        for (int k = 0; k < 63; k++) do_req(2'd0, 1, 0, 0, 8'h05, 32'h00400ABC);
        chk("R10", "index at 63", 32'(repl_idx), 63);
        chk("R1", "entries cleared by reset", 32'(rsp_exc), 1);
        do_req(2'd0, 1, 0, 0, 8'h05, 32'h00400ABC);
        chk("R10", "wrap at table size", 32'(repl_idx), 0);
        cfg_base = 6'd5;
        for (int k = 0; k < 4; k++) do_req(2'd1, 1, 0, 0, 8'h05, 32'h00001000);
        chk("R10", "index at 4 with base 5", 32'(repl_idx), 4);
        chk("R2", "store miss code", 32'(rsp_exc), 2);
        do_req(2'd1, 1, 0, 1, 8'h05, 32'h00001000);
        chk("R11", "probe before base wrap", 32'(repl_idx), 4);
        do_req(2'd0, 1, 0, 0, 8'h05, 32'h00001000);
        chk("R10", "wrap at base", 32'(repl_idx), 0);
        repeat (3) @(posedge clk); #1;
        chk("R10", "index held without requests", 32'(repl_idx), 0);

        done = 1;
        summary();
    end
endmodule